// File: doc/BRIEF.md
# Bus Configuration and Chip-Enable Controller

This block holds the bus setup of a small microcontroller. Software reaches two byte-wide registers over a simple register bus. The first is a bus-control register, which holds four chip-enable pin enables, a chip-select window size and a bus mode. The second is a stack-page register, which holds the upper address byte of the stack. Each of the four chip-enable pins carries either the chip-select from the address decoder or the matching general-purpose port output bit, depending on its enable.

Reset values depend on a processor-mode strap, `mpu_mode_i`. Low selects operation from internal ROM, and high selects operation from external memory only. When the strap is high, the reset bus mode comes from a fixed option input. An interrupt-mask output holds every interrupt, including the non-maskable one, until software has written both registers. Each stack-page write adds a further block that lasts one instruction period. The instruction period is marked by an instruction-complete strobe.

Register address 0 is bus control and address 1 is stack page. Reads are combinational from the address.

Top module: `bus_cfg_ctrl`

## Requirements
- R1: After reset, the bus-control register reads as follows. Bit 0 (CE0 enable) equals `mpu_mode_i`. Bits 3:1 (CE3..CE1 enables) are 0. Bits 5:4 (window) are 2'b11.
- R2: After reset, bits 7:6 (bus mode: 00 single-chip, 01 expanded 64K, 10 expanded 512K minimum, 11 expanded 512K maximum) depend on the strap. They are 00 when `mpu_mode_i`=0. When `mpu_mode_i`=1 they equal `opt_mode_i`, except that an option of 00 gives 11. `bus_mode_o` always equals bits 7:6.
- R3: With `mpu_mode_i`=0, a write to address 0 stores all 8 bits, and every bit reads back as written.
- R4: With `mpu_mode_i`=1, a write to address 0 whose bits 7:6 are 00 leaves the bus mode unchanged. Bits 5:0 of that write are still stored.
- R5: For each pin i, `ce_pin_o[i]` follows `ce_sel_i[i]` when enable bit i is 1, and `port_data_i[i]` when it is 0.
- R6: `win_size_o` (11 64K, 10 32K, 01 16K, 00 8K) equals bits 5:4 in expanded 64K mode. In every other bus mode it is 2'b11.
- R7: The stack page reads 8'h00 after reset. A write to address 1 stores the written value, but any value above 8'h27 is stored as 8'h27. Reads return the stored value.
- R8: `stack_page_o` equals the stored page in the two 512K modes. It is 8'h00 in single-chip and expanded 64K modes.
- R9: After reset, `irq_mask_o` stays 1 until each register has been written at least once, in either order.
- R10: A stack-page write holds `irq_mask_o` at 1 until the first `insn_done_i` pulse in a later cycle. A strobe in the same cycle as the write does not count. The mask can fall in the cycle after that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mpu_mode_i | input | 1 | Processor-mode strap, 1 = external memory only |
| opt_mode_i | input | 2 | Fixed reset bus mode used when the strap is 1 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 bus control, 1 stack page |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| insn_done_i | input | 1 | Instruction-complete strobe |
| ce_sel_i | input | 4 | Chip-selects from the address decoder |
| port_data_i | input | 4 | Port output bits shared with the chip-enable pins |
| ce_pin_o | output | 4 | Chip-enable / port pins |
| bus_mode_o | output | 2 | Active bus mode |
| win_size_o | output | 2 | Effective chip-select window size |
| stack_page_o | output | 8 | Effective stack page |
| irq_mask_o | output | 1 | 1 blocks all interrupts, including NMI |

## Verification
A wrong stored enable, window or mode bit is visible at once on the combinational readback. It also shows within the same cycle on `ce_pin_o`, `win_size_o` or `stack_page_o` once the port and decoder inputs are swept. A stuck or early-clearing mask flag appears at `irq_mask_o` one edge after the write or strobe that should have moved it. A missing clamp or a wrong mode-gating path shows in the first read, or the first exported page, after the offending write.

// File: rtl/bus_cfg_pkg.sv
package bus_cfg_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXP64  = 2'b01,
    MODE_MIN512 = 2'b10,
    MODE_MAX512 = 2'b11
  } bus_mode_e;

  localparam int unsigned RegW = 8;
  localparam logic [1:0]  WinMax = 2'b11;
endpackage

// File: rtl/bus_ctrl_reg.sv
module bus_ctrl_reg
  import bus_cfg_pkg::*;
#(
  parameter int unsigned NUM_CE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mpu_mode_i,
  input  logic [1:0]        opt_mode_i,
  input  logic              wr_i,
  input  logic [RegW-1:0]   wdata_i,
  output logic [NUM_CE-1:0] ce_en_o,
  output logic [1:0]        win_o,
  output bus_mode_e         mode_o
);
  localparam int unsigned WinLsb  = NUM_CE;
  localparam int unsigned ModeLsb = NUM_CE + 2;

  logic [NUM_CE-1:0] ce_q;
  logic [1:0]        win_q;
  bus_mode_e         mode_q, rst_mode;
  logic [1:0]        wr_mode;

  assign wr_mode = wdata_i[ModeLsb+:2];

  always_comb begin
    if (!mpu_mode_i)              rst_mode = MODE_SINGLE;
    else if (opt_mode_i == 2'b00) rst_mode = MODE_MAX512;
    else                          rst_mode = bus_mode_e'(opt_mode_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= {{(NUM_CE-1){1'b0}}, mpu_mode_i};
      win_q  <= WinMax;
      mode_q <= rst_mode;
    end else if (wr_i) begin
      ce_q  <= wdata_i[NUM_CE-1:0];
      win_q <= wdata_i[WinLsb+:2];
      // single-chip has no meaning without internal ROM
      if (!(mpu_mode_i && wr_mode == 2'b00)) mode_q <= bus_mode_e'(wr_mode);
    end
  end

  assign ce_en_o = ce_q;
  assign win_o   = win_q;
  assign mode_o  = mode_q;

  p_mode_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && mpu_mode_i && wr_mode == 2'b00) |=> $stable(mode_q));

  p_mpu_expanded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mpu_mode_i |-> (mode_q != MODE_SINGLE));
endmodule

// File: rtl/stack_page_reg.sv
module stack_page_reg
  import bus_cfg_pkg::*;
#(
  parameter int unsigned      PW       = 8,
  parameter logic [PW-1:0]    PAGE_MAX = 8'h27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [PW-1:0] wdata_i,
  input  bus_mode_e     mode_i,
  output logic [PW-1:0] page_q_o,
  output logic [PW-1:0] page_o
);
  logic [PW-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_q <= '0;
    else if (wr_i) page_q <= (wdata_i > PAGE_MAX) ? PAGE_MAX : wdata_i;
  end

  assign page_q_o = page_q;
  // paging only exists in the 512K modes
  assign page_o   = (mode_i == MODE_MIN512 || mode_i == MODE_MAX512) ? page_q : '0;

  p_page_limit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_q <= PAGE_MAX);
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic sp_wr_i,
  input  logic insn_done_i,
  output logic irq_mask_o
);
  logic ctrl_seen_q, sp_seen_q, sp_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_seen_q <= 1'b0;
      sp_seen_q   <= 1'b0;
      sp_hold_q   <= 1'b0;
    end else begin
      if (ctrl_wr_i) ctrl_seen_q <= 1'b1;
      if (sp_wr_i) begin
        sp_seen_q <= 1'b1;
        sp_hold_q <= 1'b1;
      end else if (insn_done_i) begin
        sp_hold_q <= 1'b0;
      end
    end
  end

  assign irq_mask_o = !ctrl_seen_q || !sp_seen_q || sp_hold_q;

  p_sp_write_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_wr_i |=> irq_mask_o);

  p_release_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_mask_o) |-> ($past(insn_done_i) || $past(ctrl_wr_i)));
endmodule

// File: rtl/ce_port_mux.sv
module ce_port_mux #(
  parameter int unsigned NUM_CE = 4
) (
  input  logic [NUM_CE-1:0] ce_en_i,
  input  logic [NUM_CE-1:0] ce_sel_i,
  input  logic [NUM_CE-1:0] port_data_i,
  output logic [NUM_CE-1:0] pin_o
);
  for (genvar i = 0; i < NUM_CE; i++) begin : g_pin
    assign pin_o[i] = ce_en_i[i] ? ce_sel_i[i] : port_data_i[i];
  end
endmodule

// File: rtl/bus_cfg_ctrl.sv
module bus_cfg_ctrl
  import bus_cfg_pkg::*;
#(
  parameter int unsigned NUM_CE   = 4,
  parameter logic [7:0]  PAGE_MAX = 8'h27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mpu_mode_i,
  input  logic [1:0]        opt_mode_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [RegW-1:0]   reg_wdata_i,
  output logic [RegW-1:0]   reg_rdata_o,
  input  logic              insn_done_i,
  input  logic [NUM_CE-1:0] ce_sel_i,
  input  logic [NUM_CE-1:0] port_data_i,
  output logic [NUM_CE-1:0] ce_pin_o,
  output logic [1:0]        bus_mode_o,
  output logic [1:0]        win_size_o,
  output logic [RegW-1:0]   stack_page_o,
  output logic              irq_mask_o
);
  logic              ctrl_wr, sp_wr;
  logic [NUM_CE-1:0] ce_en;
  logic [1:0]        win;
  bus_mode_e         mode;
  logic [RegW-1:0]   page_q;

  assign ctrl_wr = reg_wr_i && !reg_addr_i;
  assign sp_wr   = reg_wr_i &&  reg_addr_i;

  bus_ctrl_reg #(.NUM_CE(NUM_CE)) u_ctrl (
    .clk_i, .rst_ni, .mpu_mode_i, .opt_mode_i,
    .wr_i(ctrl_wr), .wdata_i(reg_wdata_i),
    .ce_en_o(ce_en), .win_o(win), .mode_o(mode)
  );

  stack_page_reg #(.PW(RegW), .PAGE_MAX(PAGE_MAX)) u_sp (
    .clk_i, .rst_ni, .wr_i(sp_wr), .wdata_i(reg_wdata_i), .mode_i(mode),
    .page_q_o(page_q), .page_o(stack_page_o)
  );

  irq_gate u_gate (
    .clk_i, .rst_ni, .ctrl_wr_i(ctrl_wr), .sp_wr_i(sp_wr),
    .insn_done_i, .irq_mask_o
  );

  ce_port_mux #(.NUM_CE(NUM_CE)) u_mux (
    .ce_en_i(ce_en), .ce_sel_i, .port_data_i, .pin_o(ce_pin_o)
  );

  assign bus_mode_o  = mode;
  assign win_size_o  = (mode == MODE_EXP64) ? win : WinMax;
  assign reg_rdata_o = reg_addr_i ? page_q : {mode, win, ce_en};
endmodule

// File: tb/bus_cfg_ctrl_test.sv
`timescale 1ns/1ps
module bus_cfg_ctrl_test;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       mpu_mode_i = 1'b0;
  logic [1:0] opt_mode_i = 2'b00;
  logic       reg_wr_i = 1'b0, reg_addr_i = 1'b0, insn_done_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [3:0] ce_sel_i = '0, port_data_i = '0;
  logic [7:0] reg_rdata_o, stack_page_o;
  logic [3:0] ce_pin_o;
  logic [1:0] bus_mode_o, win_size_o;
  logic       irq_mask_o;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  bus_cfg_ctrl uut (.clk_i(clk), .*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic mpu, logic [1:0] opt);
    @(negedge clk);
    rst_ni = 1'b0; mpu_mode_i = mpu; opt_mode_i = opt; reg_wr_i = 1'b0; insn_done_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic strobe();
    insn_done_i = 1'b1;
    @(negedge clk);
    insn_done_i = 1'b0;
  endtask

  function automatic logic [1:0] rst_mode(logic mpu, logic [1:0] opt);
    if (!mpu) return 2'b00;
    return (opt == 2'b00) ? 2'b11 : opt;
  endfunction

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d, exp_page;
    logic [1:0] m;
    // R1 R2 reset values over strap and option
    for (int s = 0; s < 8; s++) begin
      do_reset(s[2], s[1:0]);
      rd(1'b0, d);
      m = rst_mode(s[2], s[1:0]);
      chk("R1 reset ctrl", d, {m, 2'b11, 3'b000, s[2]});
      chk("R2 bus_mode_o", {6'b0, bus_mode_o}, {6'b0, m});
      rd(1'b1, d);
      chk("R7 reset page", d, 8'h00);
      chk("R9 reset mask", {7'b0, irq_mask_o}, 8'h01);
    end

    // R3 R5 R6 full sweep of control writes in MCU strap
    do_reset(1'b0, 2'b00);
    for (int w = 0; w < 256; w++) begin
      wr(1'b0, w[7:0]);
      rd(1'b0, d);
      chk("R3 readback", d, w[7:0]);
      chk("R6 window", {6'b0, win_size_o}, {6'b0, (w[7:6] == 2'b01) ? w[5:4] : 2'b11});
      for (int p = 0; p < 16; p++) begin
        port_data_i = p[3:0]; ce_sel_i = ~p[3:0]; #1;
        chk("R5 pin mux", {4'b0, ce_pin_o},
            {4'b0, (w[3:0] & ~p[3:0]) | (~w[3:0] & p[3:0])});
      end
    end

    // R4 MPU strap: mode field 00 ignored
    do_reset(1'b1, 2'b01);
    m = 2'b01;
    for (int w = 0; w < 256; w++) begin
      wr(1'b0, w[7:0]);
      if (w[7:6] != 2'b00) m = w[7:6];
      rd(1'b0, d);
      chk("R4 mode guard", d, {m, w[5:0]});
    end

    // R7 R8 stack page sweep in each bus mode
    do_reset(1'b0, 2'b00);
    for (int md = 0; md < 4; md++) begin
      wr(1'b0, {md[1:0], 6'h00});
      for (int w = 0; w < 256; w += 3) begin
        wr(1'b1, w[7:0]);
        exp_page = (w > 8'h27) ? 8'h27 : w[7:0];
        rd(1'b1, d);
        chk("R7 clamp", d, exp_page);
        chk("R8 export", stack_page_o, md[1] ? exp_page : 8'h00);
      end
    end

    // R9 R10 mask ordering: control first
    do_reset(1'b0, 2'b00);
    wr(1'b0, 8'hC0);
    chk("R9 ctrl only", {7'b0, irq_mask_o}, 8'h01);
    strobe();
    chk("R9 ctrl only strobe", {7'b0, irq_mask_o}, 8'h01);
    wr(1'b1, 8'h05);
    chk("R10 hold after sp", {7'b0, irq_mask_o}, 8'h01);
    @(negedge clk);
    chk("R10 hold no strobe", {7'b0, irq_mask_o}, 8'h01);
    strobe();
    chk("R10 release", {7'b0, irq_mask_o}, 8'h00);
    // same-cycle strobe does not count
    insn_done_i = 1'b1;
    wr(1'b1, 8'h06);
    insn_done_i = 1'b0;
    chk("R10 same-cycle strobe", {7'b0, irq_mask_o}, 8'h01);
    strobe();
    chk("R10 release 2", {7'b0, irq_mask_o}, 8'h00);

    // R9 stack page first
    do_reset(1'b1, 2'b11);
    wr(1'b1, 8'h01);
    strobe();
    chk("R9 sp only", {7'b0, irq_mask_o}, 8'h01);
    wr(1'b0, 8'hC1);
    chk("R9 both written", {7'b0, irq_mask_o}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule